// File: doc/BRIEF.md
# Relocatable Scratch RAM with Dual Address Windows

This block holds a 4 KiB word-organised RAM that the rest of the chip sees through two address windows. One window serves instruction fetch and one serves data. Each window has a base register and a control register whose top bit turns it on. Software places a window by writing its base register, and the base is aligned to a 64 MiB boundary. Both windows are views of the same physical words. Anything written through one window can be read back through the other.

Memory traffic arrives on a single-beat 32-bit request port. Each request is decoded against the enabled windows. A hit reads or writes the shared RAM, and a request that matches no window is answered with a miss. The response comes one clock after the request. It reports which window served the access. When both windows sit on the same base, the access counts as a single hit on the instruction window. Configuration is done through a four-entry register port with a combinational read path.

Top module: `rsm_top`

## Requirements
- R1: After reset, all four configuration registers read zero and both windows are disabled, so every access misses.
- R2: The register selector `cfg_sel` encodes 0 = instruction base, 1 = data base, 2 = instruction control, 3 = data control. A base write keeps bits 31:26 only, and a control write keeps bits 31:30 only. Every other bit reads back as zero.
- R3: Bit 31 of a control register enables its window. A request hits a window when that window is enabled and `mem_addr[31:26]` equals the stored base bits 31:26.
- R4: Every request is answered exactly one cycle later, with `rsp_valid` high. `rsp_rdata` carries the RAM word for a read hit and zero for writes and misses.
- R5: Both windows address the same storage, so a word written through the data window reads back through the instruction window.
- R6: The RAM word index is `mem_addr[11:2]`. Address bits 25:12 and 1:0 are ignored, so a window aliases the 4 KiB RAM throughout its 64 MiB span.
- R7: `rsp_win` bit 0 marks an instruction-window hit and bit 1 marks a data-window hit. When both windows match, exactly one hit is reported, as `rsp_win = 2'b01`.
- R8: A request that misses raises `rsp_miss` with `rsp_win = 0`. A write that misses leaves every RAM word unchanged.
- R9: A request in the cycle after a configuration write is decoded with the new settings. A request in the same cycle as the write is decoded with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Configuration register select, used for both writes and reads |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored value of the selected register, read combinationally |
| mem_req | input | 1 | Memory request valid |
| mem_we | input | 1 | Request is a write (1) or a read (0) |
| mem_addr | input | 32 | Request byte address |
| mem_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_miss | output | 1 | Request matched no enabled window |
| rsp_win | output | 2 | Window that served the hit: bit 0 instruction, bit 1 data |
| rsp_rdata | output | 32 | Read data, zero for writes and misses |

## Verification
A configuration write and a memory access can land in the same clock. The access must then be decoded against the settings that were in force before the write, and the next access against the settings after it. The bench drives a control-register write that disables a live window in the same cycle as a read of that window. It expects a hit carrying the stored word. It then issues a second read and expects a miss. The bench also relocates a window and checks that its old address stops responding at once. Both windows are placed on one base to confirm that the overlap yields a single instruction-window hit.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int unsigned RSM_W   = 32;
  localparam int unsigned CTL_LSB = 30;

  typedef enum logic [1:0] {
    REG_IBASE = 2'd0,
    REG_DBASE = 2'd1,
    REG_ICTL  = 2'd2,
    REG_DCTL  = 2'd3
  } rsm_reg_e;
endpackage

// File: rtl/rsm_rst_sync.sv
module rsm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/rsm_cfg_regs.sv
module rsm_cfg_regs #(
  parameter int unsigned W        = 32,
  parameter int unsigned BASE_LSB = 26,
  parameter int unsigned CTL_LSB  = 30
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [1:0]                        sel,
  input  logic [W-1:0]                      wr_data,
  output logic [W-1:0]                      rd_data,
  output logic [1:0][W-BASE_LSB-1:0]        win_tag,
  output logic [1:0]                        win_en
);
  import rsm_pkg::*;

  localparam int unsigned    N_WIN     = 2;
  localparam logic [W-1:0]   BASE_MASK = {W{1'b1}} << BASE_LSB;
  localparam logic [W-1:0]   CTL_MASK  = {W{1'b1}} << CTL_LSB;

  logic [N_WIN-1:0][W-1:0] base_q, ctl_q, base_d, ctl_d;
  logic [N_WIN-1:0]        base_ce, ctl_ce;

  // next-state and clock enables
  always_comb begin
    for (int g = 0; g < N_WIN; g++) begin
      base_ce[g] = wr_en && (sel == 2'(g));
      ctl_ce[g]  = wr_en && (sel == 2'(g + N_WIN));
      base_d[g]  = wr_data & BASE_MASK;
      ctl_d[g]   = wr_data & CTL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ctl_q  <= '0;
    end else begin
      for (int g = 0; g < N_WIN; g++) begin
        if (base_ce[g]) base_q[g] <= base_d[g];
        if (ctl_ce[g])  ctl_q[g]  <= ctl_d[g];
      end
    end
  end

  always_comb begin
    case (sel)
      REG_IBASE: rd_data = base_q[0];
      REG_DBASE: rd_data = base_q[1];
      REG_ICTL:  rd_data = ctl_q[0];
      default:   rd_data = ctl_q[1];
    endcase
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_win_out
    assign win_tag[g] = base_q[g][W-1:BASE_LSB];
    assign win_en[g]  = ctl_q[g][W-1];
  end
endmodule

// File: rtl/rsm_win_decode.sv
module rsm_win_decode #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned N_WIN = 2
) (
  input  logic [TAG_W-1:0]            tag,
  input  logic [N_WIN-1:0][TAG_W-1:0] win_tag,
  input  logic [N_WIN-1:0]            win_en,
  output logic [N_WIN-1:0]            win_sel,
  output logic                        any_hit
);
  logic [N_WIN-1:0] raw;

  for (genvar g = 0; g < N_WIN; g++) begin : g_match
    assign raw[g] = win_en[g] && (tag == win_tag[g]);
  end

  // lowest index wins, so an overlap yields a single hit
  always_comb begin
    logic taken;
    taken   = 1'b0;
    win_sel = '0;
    for (int g = 0; g < N_WIN; g++) begin
      if (raw[g] && !taken) begin
        win_sel[g] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  assign any_hit = |raw;
endmodule

// File: rtl/rsm_store.sv
module rsm_store #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata_q  <= mem[idx];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rsm_top.sv
module rsm_top #(
  parameter int unsigned BASE_LSB  = 26,
  parameter int unsigned RAM_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mem_req,
  input  logic        mem_we,
  input  logic [31:0] mem_addr,
  input  logic [31:0] mem_wdata,
  output logic        rsp_valid,
  output logic        rsp_miss,
  output logic [1:0]  rsp_win,
  output logic [31:0] rsp_rdata
);
  import rsm_pkg::*;

  localparam int unsigned W       = RSM_W;
  localparam int unsigned N_WIN   = 2;
  localparam int unsigned OFF_LSB = 2;
  localparam int unsigned WORD_AW = $clog2(RAM_BYTES / 4);
  localparam int unsigned TAG_W   = W - BASE_LSB;

  logic                        rst_core_n;
  logic [N_WIN-1:0][TAG_W-1:0] win_tag;
  logic [N_WIN-1:0]            win_en;
  logic [N_WIN-1:0]            win_sel;
  logic                        any_hit;
  logic                        hit;
  logic [W-1:0]                ram_rdata;
  logic                        unused_addr_bits;

  logic             valid_d, valid_q;
  logic             miss_d,  miss_q;
  logic [N_WIN-1:0] win_d,   win_q;
  logic             rdok_d,  rdok_q;

  rsm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  rsm_cfg_regs #(.W(W), .BASE_LSB(BASE_LSB), .CTL_LSB(CTL_LSB)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (cfg_we),
    .sel     (cfg_sel),
    .wr_data (cfg_wdata),
    .rd_data (cfg_rdata),
    .win_tag (win_tag),
    .win_en  (win_en)
  );

  rsm_win_decode #(.TAG_W(TAG_W), .N_WIN(N_WIN)) u_dec (
    .tag     (mem_addr[W-1:BASE_LSB]),
    .win_tag (win_tag),
    .win_en  (win_en),
    .win_sel (win_sel),
    .any_hit (any_hit)
  );

  assign hit = mem_req && any_hit;

  rsm_store #(.W(W), .AW(WORD_AW)) u_ram (
    .clk   (clk),
    .wr_en (hit && mem_we),
    .rd_en (hit && !mem_we),
    .idx   (mem_addr[OFF_LSB +: WORD_AW]),
    .wdata (mem_wdata),
    .rdata (ram_rdata)
  );

  assign unused_addr_bits = ^{mem_addr[BASE_LSB-1:OFF_LSB+WORD_AW], mem_addr[OFF_LSB-1:0]};

  // response next-state
  always_comb begin
    valid_d = mem_req;
    miss_d  = mem_req && !any_hit;
    win_d   = mem_req ? win_sel : '0;
    rdok_d  = hit && !mem_we;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
      win_q   <= '0;
      rdok_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      miss_q  <= miss_d;
      win_q   <= win_d;
      rdok_q  <= rdok_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_miss  = miss_q;
  assign rsp_win   = win_q;
  assign rsp_rdata = rdok_q ? ram_rdata : '0;
endmodule

// File: rtl/rsm_chk.sv
module rsm_chk #(
  parameter int unsigned BASE_LSB = 26,
  parameter int unsigned CTL_LSB  = 30
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_rdata,
  input logic        mem_req,
  input logic        rsp_valid,
  input logic        rsp_miss,
  input logic [1:0]  rsp_win,
  input logic [31:0] rsp_rdata
);
  // R4
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> rsp_valid);

  // R4
  idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |=> !rsp_valid);

  // R7
  win_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_win));

  // R8
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_win == 2'b00 && rsp_rdata == 32'h0));

  // R3
  hit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |-> ($countones(rsp_win) == 1));

  // R2
  base_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel[1] |-> (cfg_rdata[BASE_LSB-1:0] == '0));

  // R2
  ctl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel[1] |-> (cfg_rdata[CTL_LSB-1:0] == '0));
endmodule

bind rsm_top rsm_chk #(.BASE_LSB(BASE_LSB), .CTL_LSB(CTL_LSB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .cfg_sel   (cfg_sel),
  .cfg_rdata (cfg_rdata),
  .mem_req   (mem_req),
  .rsp_valid (rsp_valid),
  .rsp_miss  (rsp_miss),
  .rsp_win   (rsp_win),
  .rsp_rdata (rsp_rdata)
);

// File: tb/sim_rsm_top.sv
module sim_rsm_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        rsp_valid;
  logic        rsp_miss;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic        r_valid, r_miss;
  logic [1:0]  r_win;
  logic [31:0] r_data;

  always #4 clk = ~clk;

  rsm_top u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_win(rsp_win), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'h3C00_0000 ^ (32'(i) * 32'h0004_1011);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] sel, output logic [31:0] data);
    @(negedge clk);
    cfg_sel = sel;
    #1 data = cfg_rdata;
  endtask

  task automatic acc(input logic we, input logic [31:0] addr, input logic [31:0] wd);
    @(negedge clk);
    mem_req = 1'b1; mem_we = we; mem_addr = addr; mem_wdata = wd;
    @(negedge clk);
    mem_req = 1'b0; mem_we = 1'b0;
    r_valid = rsp_valid; r_miss = rsp_miss; r_win = rsp_win; r_data = rsp_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values and all-miss
    for (int s = 0; s < 4; s++) begin
      cfg_rd(2'(s), v);
      chk("R1 reg reset", v, 32'h0);
    end
    acc(1'b0, 32'h0000_0010, 32'h0);
    chk("R1 access after reset misses", {30'h0, r_valid, r_miss}, 32'h3);
    chk("R8 miss window code", {30'h0, r_win}, 32'h0);

    // R2: register masking
    for (int s = 0; s < 4; s++) begin
      cfg_wr(2'(s), 32'hFFFF_FFFF);
      cfg_rd(2'(s), v);
      chk("R2 all-ones mask", v, (s < 2) ? 32'hFC00_0000 : 32'hC000_0000);
      cfg_wr(2'(s), 32'h5A5A_5A5A);
      cfg_rd(2'(s), v);
      chk("R2 pattern mask", v, (s < 2) ? 32'h5800_0000 : 32'h4000_0000);
      cfg_wr(2'(s), 32'h0);
    end
    // bit 30 alone must not enable (R3)
    cfg_wr(2'd2, 32'h4000_0000);
    acc(1'b0, 32'h0000_0000, 32'h0);
    chk("R3 bit30 does not enable", {31'h0, r_miss}, 32'h1);
    cfg_wr(2'd2, 32'h0);

    // R3 / R4 / R7: base sweep for each window alone
    for (int w = 0; w < 2; w++) begin
      cfg_wr(2'(w + 2), 32'h8000_0000);
      for (int b = 0; b < 64; b++) begin
        cfg_wr(2'(w), 32'(b) << 26);
        acc(1'b1, (32'(b) << 26) | 32'(b * 4), pat(b));
        chk("R3 hit at base", {30'h0, r_valid, r_miss}, 32'h2);
        chk("R7 window code", {30'h0, r_win}, 32'(1 << w));
        chk("R4 write rdata zero", r_data, 32'h0);
        acc(1'b0, 32'((b + 1) % 64) << 26, 32'h0);
        chk("R3 miss off base", {31'h0, r_miss}, 32'h1);
      end
      cfg_wr(2'(w + 2), 32'h0);
      cfg_wr(2'(w), 32'h0);
    end

    // R5 / R6: fill via data window, read via instruction window with aliasing
    cfg_wr(2'd0, 32'h0800_0000);
    cfg_wr(2'd1, 32'h0C00_0000);
    cfg_wr(2'd2, 32'h8000_0000);
    cfg_wr(2'd3, 32'h8000_0000);
    for (int i = 0; i < 1024; i++)
      acc(1'b1, 32'h0C00_0000 + 32'(i * 4), pat(i));
    for (int i = 0; i < 1024; i++) begin
      acc(1'b0, 32'h0800_0000 + 32'(i * 4) + 32'((i % 7 + 1) * 32'h1000) + 32'(i % 4), 32'h0);
      chk("R5 R6 shared aliased read", r_data, pat(i));
      if (i % 128 == 0) chk("R7 inst window code", {30'h0, r_win}, 32'h1);
    end
    acc(1'b0, 32'h0FFF_F000 + 32'h24, 32'h0);
    chk("R6 data window top alias", r_data, pat(9));

    // R8: missed write changes nothing
    acc(1'b1, 32'h4000_0014, 32'hDEAD_BEEF);
    chk("R8 write miss flagged", {31'h0, r_miss}, 32'h1);
    acc(1'b0, 32'h0800_0014, 32'h0);
    chk("R8 storage untouched", r_data, pat(5));
    acc(1'b0, 32'h4000_0014, 32'h0);
    chk("R8 read miss data zero", r_data, 32'h0);

    // R7: overlap at same base
    cfg_wr(2'd1, 32'h0800_0000);
    acc(1'b0, 32'h0800_0024, 32'h0);
    chk("R7 overlap single hit", {30'h0, r_win}, 32'h1);
    chk("R7 overlap data", r_data, pat(9));
    acc(1'b1, 32'h0800_0024, 32'h1234_5678);
    acc(1'b0, 32'h0800_0024, 32'h0);
    chk("R7 overlap write-read", r_data, 32'h1234_5678);
    cfg_wr(2'd2, 32'h0);
    acc(1'b0, 32'h0800_0024, 32'h0);
    chk("R7 data window after inst off", {30'h0, r_win}, 32'h2);

    // R9: relocation takes effect on next cycle
    cfg_wr(2'd1, 32'h1000_0000);
    acc(1'b0, 32'h0800_0024, 32'h0);
    chk("R9 old base stops", {31'h0, r_miss}, 32'h1);
    acc(1'b0, 32'h1000_0024, 32'h0);
    chk("R9 new base hits", r_data, 32'h1234_5678);

    // R9: write and access in the same cycle uses old settings
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h0;
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = 32'h1000_0028;
    @(negedge clk);
    cfg_we = 1'b0; mem_req = 1'b0;
    chk("R9 same-cycle old settings", {31'h0, rsp_miss}, 32'h0);
    chk("R9 same-cycle data", rsp_rdata, pat(10));
    acc(1'b0, 32'h1000_0028, 32'h0);
    chk("R9 disabled next access", {31'h0, r_miss}, 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule